// File: doc/BRIEF.md
# Frame Pad and CRC Appender

This stage sits in a transmit byte path between a frame source and the
serializer that adds preamble and line coding. It accepts a frame one byte per
handshake, beginning with the destination address, and passes each byte through
unchanged. When the frame is too short, it inserts zero bytes so that the frame,
including its check sequence, reaches the minimum length. It then appends a
four-byte CRC-32 covering every byte it sent from the destination address to the
last data or pad byte.

Two control inputs turn padding and CRC insertion off independently. With CRC
insertion off, the frame ends with its last input byte or pad byte. This lets a
test source send a deliberately corrupted check sequence, and lets a bridge
forward a check sequence that was already computed upstream. Both control inputs
are captured on the first byte of a frame and hold for the whole frame.

Both sides use a valid/ready handshake. Data bytes flow combinationally from
input to output, so the stage adds no latency. While it emits pad or CRC bytes,
the stage holds off the input.

Top module: `fcs_pad_stage`

## Requirements
- R1: While data bytes are being forwarded, `out_data` equals `in_data`, `out_valid` follows `in_valid`, and `in_ready` follows `out_ready`. Bytes keep their order.
- R2: With padding and CRC both enabled, a frame with fewer than MIN_FRAME-4 input bytes (60 by default) is extended to exactly MIN_FRAME-4 bytes before the CRC, for MIN_FRAME (64) bytes in total.
- R3: Every inserted pad byte has the value 0x00.
- R4: When `pad_off` is 1 at the first byte of a frame, no pad bytes are inserted, whatever the frame length.
- R5: The appended check sequence uses the reflected CRC-32 algorithm: generator 0x04C11DB7 (0xEDB88320 in reflected form), register preset to 0xFFFFFFFF, and each byte fed bit 0 first. It covers all data and pad bytes. The final register is complemented and sent as 4 bytes, least significant byte first.
- R6: When `crc_off` is 1 at the first byte of a frame, no CRC bytes are sent. If padding is enabled, the pad target becomes MIN_FRAME bytes.
- R7: `pad_off` and `crc_off` are sampled with the first byte of a frame. Changes on them later in the same frame do not affect that frame.
- R8: `out_last` is 1 on exactly one output byte per frame: the final one, whether it is data, pad or CRC.
- R9: From the handshake that accepts the input byte marked `in_last` until the final output byte is accepted, `in_ready` stays 0.
- R10: A pad or CRC byte presented while `out_ready` is 0 stays valid and unchanged until it is accepted.
- R11: After reset, with no input offered, `out_valid` is 0.
- R12: A frame of MIN_FRAME-4 input bytes or more gets no pad bytes, only the CRC.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| pad_off | input | 1 | 1 disables pad insertion for the frame starting now |
| crc_off | input | 1 | 1 disables CRC insertion for the frame starting now |
| in_valid | input | 1 | Input byte present |
| in_data | input | 8 | Input frame byte |
| in_last | input | 1 | Marks the final input byte of a frame |
| in_ready | output | 1 | Stage accepts the input byte this cycle |
| out_valid | output | 1 | Output byte present |
| out_data | output | 8 | Output frame byte |
| out_last | output | 1 | Marks the final output byte of a frame |
| out_ready | input | 1 | Downstream accepts the output byte this cycle |

## Verification
Frame lengths are chosen around the pad boundary: 1, 20, 59, 60 and 100 bytes.
Comparing 59 with 60 bytes shows whether the threshold is off by one. Comparing
1 or 20 bytes with 100 bytes tells a padded frame from one that only gets a CRC.
The four settings of the two control bits show whether each bit acts alone, and
the CRC-off case shows that the pad target moves to the full minimum length. A
frame that toggles both control bits after its first byte tells sampling from
live use. A frame sent under periodic output stalls checks flow-through
backpressure, the held tail bytes and the stalled input, and it must give the
same bytes as an unstalled frame.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    localparam int CRC_W     = 32;
    localparam int CRC_BYTES = CRC_W / 8;

    typedef enum logic [1:0] {
        ST_DATA = 2'd0,
        ST_PAD  = 2'd1,
        ST_CRC  = 2'd2
    } fcs_state_e;

    typedef struct packed {
        fcs_state_e       state;
        logic [CRC_W-1:0] crc;
        logic [1:0]       idx;
        logic             pad_off;
        logic             crc_off;
    } fcs_regs_t;

endpackage

// File: rtl/fcs_crc32_step.sv
module fcs_crc32_step #(
    parameter logic [31:0] POLY_REFL = 32'hEDB88320,
    parameter int          BYTE_W    = 8
) (
    input  logic [31:0]       crc_in,
    input  logic [BYTE_W-1:0] byte_in,
    output logic [31:0]       crc_out
);

    // Feeds one byte into the reflected CRC register, bit 0 first, one step per bit
    always_comb begin
        logic [31:0] c;
        c = crc_in;
        for (int b = 0; b < BYTE_W; b++) begin
            if (c[0] ^ byte_in[b]) begin
                c = (c >> 1) ^ POLY_REFL;
            end else begin
                c = c >> 1;
            end
        end
        crc_out = c;
    end

endmodule

// File: rtl/fcs_len_count.sv
module fcs_len_count #(
    parameter int CNT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] cnt
);

    localparam logic [CNT_W-1:0] CNT_MAX = '1;

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (clr) begin
            cnt_d = '0;
        end else if (inc && cnt_q != CNT_MAX) begin
            cnt_d = cnt_q + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign cnt = cnt_q;

endmodule

// File: rtl/fcs_pad_stage.sv
module fcs_pad_stage
    import fcs_pkg::*;
#(
    parameter int MIN_FRAME = 64,
    parameter int BYTE_W    = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              pad_off,
    input  logic              crc_off,
    input  logic              in_valid,
    input  logic [BYTE_W-1:0] in_data,
    input  logic              in_last,
    output logic              in_ready,
    output logic              out_valid,
    output logic [BYTE_W-1:0] out_data,
    output logic              out_last,
    input  logic              out_ready
);

    localparam int CNT_W = $clog2(MIN_FRAME + 1);
    localparam logic [CNT_W:0] TGT_WITH_CRC = (CNT_W + 1)'(MIN_FRAME - CRC_BYTES);
    localparam logic [CNT_W:0] TGT_NO_CRC   = (CNT_W + 1)'(MIN_FRAME);
    localparam logic [1:0]     IDX_LAST     = 2'(CRC_BYTES - 1);

    fcs_regs_t r_d, r_q;

    logic [CNT_W-1:0]  cnt;
    logic              cnt_inc, cnt_clr;
    logic              first;
    logic              po, co;
    logic [CNT_W:0]    tgt;
    logic [CNT_W:0]    cnt_p1;
    logic              reach;
    logic [31:0]       crc_base, crc_next;
    logic [BYTE_W-1:0] crc_byte;

    fcs_len_count #(.CNT_W(CNT_W)) u_len (
        .clk  (clk),
        .rst_n(rst_n),
        .clr  (cnt_clr),
        .inc  (cnt_inc),
        .cnt  (cnt)
    );

    fcs_crc32_step #(.BYTE_W(BYTE_W)) u_crc (
        .crc_in (crc_base),
        .byte_in(crc_byte),
        .crc_out(crc_next)
    );

    // The first byte of a frame uses the live controls and a preset CRC register
    assign first    = (r_q.state == ST_DATA) && (cnt == '0);
    assign po       = first ? pad_off : r_q.pad_off;
    assign co       = first ? crc_off : r_q.crc_off;
    assign tgt      = co ? TGT_NO_CRC : TGT_WITH_CRC;
    assign cnt_p1   = {1'b0, cnt} + 1'b1;
    assign reach    = cnt_p1 >= tgt;
    assign crc_base = first ? 32'hFFFF_FFFF : r_q.crc;
    assign crc_byte = (r_q.state == ST_PAD) ? '0 : in_data;

    always_comb begin
        r_d       = r_q;
        in_ready  = 1'b0;
        out_valid = 1'b0;
        out_data  = '0;
        out_last  = 1'b0;
        cnt_inc   = 1'b0;
        cnt_clr   = 1'b0;

        unique case (r_q.state)
            ST_DATA: begin
                out_valid = in_valid;
                out_data  = in_data;
                in_ready  = out_ready;
                out_last  = in_last && (po || reach) && co;
                if (in_valid && out_ready) begin
                    r_d.pad_off = po;
                    r_d.crc_off = co;
                    r_d.crc     = crc_next;
                    cnt_inc     = 1'b1;
                    if (in_last) begin
                        if (!po && !reach) begin
                            r_d.state = ST_PAD;
                        end else if (!co) begin
                            r_d.state = ST_CRC;
                            r_d.idx   = '0;
                        end else begin
                            cnt_clr = 1'b1;
                        end
                    end
                end
            end

            ST_PAD: begin
                out_valid = 1'b1;
                out_data  = '0;
                out_last  = reach && co;
                if (out_ready) begin
                    r_d.crc = crc_next;
                    cnt_inc = 1'b1;
                    if (reach) begin
                        if (co) begin
                            r_d.state = ST_DATA;
                            cnt_clr   = 1'b1;
                        end else begin
                            r_d.state = ST_CRC;
                            r_d.idx   = '0;
                        end
                    end
                end
            end

            ST_CRC: begin
                out_valid = 1'b1;
                out_data  = ~r_q.crc[{r_q.idx, 3'b000} +: BYTE_W];
                out_last  = (r_q.idx == IDX_LAST);
                if (out_ready) begin
                    r_d.idx = r_q.idx + 1'b1;
                    if (r_q.idx == IDX_LAST) begin
                        r_d.state = ST_DATA;
                        cnt_clr   = 1'b1;
                    end
                end
            end

            default: begin
                r_d.state = ST_DATA;
                cnt_clr   = 1'b1;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q.state   <= ST_DATA;
            r_q.crc     <= '1;
            r_q.idx     <= '0;
            r_q.pad_off <= 1'b0;
            r_q.crc_off <= 1'b0;
        end else begin
            r_q <= r_d;
        end
    end

endmodule

// File: rtl/fcs_pad_stage_chk.sv
module fcs_pad_stage_chk #(
    parameter int MIN_FRAME = 64,
    parameter int BYTE_W    = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pad_off,
    input logic              in_valid,
    input logic              in_last,
    input logic              in_ready,
    input logic              out_valid,
    input logic [BYTE_W-1:0] out_data,
    input logic              out_last,
    input logic              out_ready
);

    logic [15:0] ck_cnt;
    logic        ck_po;
    logic        tail;
    logic        out_hs, in_hs, eff_po;

    assign out_hs = out_valid && out_ready;
    assign in_hs  = in_valid && in_ready;
    assign eff_po = (ck_cnt == '0) ? pad_off : ck_po;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ck_cnt <= '0;
            ck_po  <= 1'b0;
            tail   <= 1'b0;
        end else begin
            if (out_hs) begin
                if (ck_cnt == '0) ck_po <= pad_off;
                ck_cnt <= out_last ? '0 : ck_cnt + 16'd1;
            end
            if (out_hs && out_last) begin
                tail <= 1'b0;
            end else if (in_hs && in_last) begin
                tail <= 1'b1;
            end
        end
    end

    AST_READY_FOLLOWS: assert property (@(posedge clk) disable iff (!rst_n)
        in_ready |-> out_ready);  // R1

    AST_MIN_LENGTH: assert property (@(posedge clk) disable iff (!rst_n)
        (out_hs && out_last && !eff_po) |-> (ck_cnt + 16'd1 >= 16'(MIN_FRAME)));  // R2

    AST_TAIL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        tail |-> !in_ready);  // R9

    AST_TAIL_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (tail && out_valid && !out_ready) |=> (out_valid && $stable(out_data) && $stable(out_last)));  // R10

endmodule

bind fcs_pad_stage fcs_pad_stage_chk #(.MIN_FRAME(MIN_FRAME), .BYTE_W(BYTE_W)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .pad_off  (pad_off),
    .in_valid (in_valid),
    .in_last  (in_last),
    .in_ready (in_ready),
    .out_valid(out_valid),
    .out_data (out_data),
    .out_last (out_last),
    .out_ready(out_ready)
);

// File: tb/fcs_pad_stage_test.sv
module fcs_pad_stage_test;

    localparam int PERIOD = 10;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       pad_off = 1'b0;
    logic       crc_off = 1'b0;
    logic       in_valid = 1'b0;
    logic [7:0] in_data = '0;
    logic       in_last = 1'b0;
    logic       in_ready;
    logic       out_valid;
    logic [7:0] out_data;
    logic       out_last;
    logic       out_ready = 1'b1;

    int checks = 0;
    int failures = 0;

    logic [7:0] frm [0:127];
    logic [7:0] exp_b [0:199];
    logic [7:0] got_b [0:199];

    fcs_pad_stage uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .pad_off  (pad_off),
        .crc_off  (crc_off),
        .in_valid (in_valid),
        .in_data  (in_data),
        .in_last  (in_last),
        .in_ready (in_ready),
        .out_valid(out_valid),
        .out_data (out_data),
        .out_last (out_last),
        .out_ready(out_ready)
    );

    always #(PERIOD / 2) clk = ~clk;

    function automatic logic [31:0] crc_upd(input logic [31:0] c, input logic [7:0] b);
        logic [31:0] r;
        r = c ^ {24'h0, b};
        for (int k = 0; k < 8; k++) begin
            r = r[0] ? ((r >> 1) ^ 32'hEDB88320) : (r >> 1);
        end
        return r;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int expv);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, expv);
        end
    endtask

    task automatic run_frame(input int len, input int seed, input bit po, input bit co,
                             input bit bp, input bit flip, input string len_req, input string dat_req);
        int n, gn, ii, cyc, bad1, bad9, bad10, mis, first_mis, tgt;
        bit done, tail, hold_pend;
        logic [7:0] held;
        logic [31:0] crc;

        for (int i = 0; i < len; i++) frm[i] = 8'((seed + i * 37 + 1) & 8'hFF);
        n = 0;
        crc = 32'hFFFF_FFFF;
        for (int i = 0; i < len; i++) begin
            exp_b[n] = frm[i];
            crc = crc_upd(crc, frm[i]);
            n++;
        end
        tgt = co ? 64 : 60;
        if (!po) begin
            while (n < tgt) begin
                exp_b[n] = 8'h00;
                crc = crc_upd(crc, 8'h00);
                n++;
            end
        end
        if (!co) begin
            for (int k = 0; k < 4; k++) begin
                exp_b[n] = 8'((~crc) >> (8 * k));
                n++;
            end
        end

        gn = 0; ii = 0; cyc = 0; bad1 = 0; bad9 = 0; bad10 = 0;
        done = 0; tail = 0; hold_pend = 0; held = '0;
        while (!done && cyc < 2000) begin
            @(negedge clk);
            out_ready = bp ? ((cyc % 3) != 1) : 1'b1;
            pad_off   = (flip && ii > 0) ? !po : po;
            crc_off   = (flip && ii > 0) ? !co : co;
            if (ii < len) begin
                in_valid = 1'b1;
                in_data  = frm[ii];
                in_last  = (ii == len - 1);
            end else begin
                in_valid = 1'b0;
                in_data  = 8'hA5;
                in_last  = 1'b0;
            end
            #1;
            if (hold_pend && !(out_valid && out_data == held)) bad10++;   // R10
            hold_pend = 0;
            if (tail && in_ready) bad9++;                                 // R9
            if (!tail && (in_ready != out_ready)) bad1++;                 // R1
            if (in_valid && in_ready) begin
                if (in_last) tail = 1;
                ii++;
            end
            if (out_valid && out_ready) begin
                if (gn < 200) got_b[gn] = out_data;
                gn++;
                if (out_last) done = 1;
            end else if (out_valid && tail) begin
                hold_pend = 1;
                held = out_data;
            end
            cyc++;
        end
        @(negedge clk);
        in_valid = 1'b0;
        in_last  = 1'b0;
        out_ready = 1'b1;

        check(gn == n, len_req, "frame length", gn, n);
        check(done, "R8", "end marker seen at final byte", int'(done), 1);
        mis = 0;
        first_mis = -1;
        for (int i = 0; i < n && i < gn; i++) begin
            if (got_b[i] !== exp_b[i]) begin
                if (first_mis < 0) first_mis = i;
                mis++;
            end
        end
        if (first_mis >= 0)
            check(0, dat_req, "byte value", int'(got_b[first_mis]), int'(exp_b[first_mis]));
        else
            check(1, dat_req, "byte values", 0, 0);
        check(bad9 == 0, "R9", "input ready during tail", bad9, 0);
        check(bad1 == 0, "R1", "ready mirror during data", bad1, 0);
        if (bp) check(bad10 == 0, "R10", "stalled tail byte changed", bad10, 0);
        if (!po && !co && len < 60) begin
            mis = 0;
            for (int i = len; i < 60 && i < gn; i++) if (got_b[i] != 8'h00) mis++;
            check(mis == 0, "R3", "nonzero pad bytes", mis, 0);
        end
    endtask

    task automatic t_reset();
        @(negedge clk);
        #1;
        check(out_valid == 1'b0, "R11", "out_valid after reset", int'(out_valid), 0);
        check(in_ready == out_ready, "R11", "in_ready after reset", int'(in_ready), int'(out_ready));
    endtask

    initial begin
        #(PERIOD * 150000);
        failures++;
        $display("FAIL watchdog expired actual=1 expected=0");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        run_frame(20, 3, 0, 0, 0, 0, "R2", "R5");    // short frame, both on
        run_frame(60, 11, 0, 0, 0, 0, "R12", "R1");  // exactly at threshold
        run_frame(59, 17, 0, 0, 0, 0, "R2", "R3");   // one pad byte
        run_frame(100, 29, 0, 0, 0, 0, "R12", "R5"); // long frame
        run_frame(20, 41, 1, 0, 0, 0, "R4", "R5");   // padding off
        run_frame(20, 53, 0, 1, 0, 0, "R6", "R3");   // CRC off, pad to 64
        run_frame(10, 67, 1, 1, 0, 0, "R4", "R6");   // both off
        run_frame(30, 71, 0, 0, 1, 0, "R2", "R10");  // output stalls
        run_frame(20, 83, 0, 0, 0, 1, "R7", "R7");   // controls toggled mid-frame
        run_frame(1, 97, 0, 0, 0, 0, "R2", "R5");    // single byte
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule